// File: doc/BRIEF.md
# Prioritised Exception Vector Controller

This block arbitrates among pending processor exceptions and performs the architectural state switch for the one it picks. It keeps a pending-flag register that upstream fault sources set through a raise vector, together with the current and next program counters, the machine state register and two save/restore registers. When the pipeline pulses the take strobe, the block chooses one exception by a fixed priority. It saves a return address and a masked copy of the machine state, rewrites the machine state, points both program counters at the handler vector and clears the serviced flag.

Synchronous faults are always eligible. The three asynchronous sources are eligible only when the external-enable bit of the machine state is set and no synchronous fault is pending. A special memory-check flag cancels a pending data-storage fault without entering a handler. A state-load port lets the surrounding core write the program counters, the machine state and the second save register. This is how the core advances execution and presets program-exception cause bits.

Top module: `exc_vector_ctrl`

## Requirements
- R1: After reset, pending flags, both program counters, the machine state and both save registers read zero.
- R2: Flag bits are 0 instruction-storage, 1 program, 2 system call, 3 FPU unavailable, 4 memory-check, 5 data-storage, 6 alignment, 7 external, 8 performance monitor, 9 decrementer. Among bits 0..6, the lowest set bit is the one serviced, and only one exception is serviced per strobe.
- R3: Handler vectors are 0x400, 0x700, 0xC00, 0x800, 0x300, 0x600, 0x500, 0xF00 and 0x900 for bits 0, 1, 2, 3, 5, 6, 7, 8 and 9. Both program counters hold the vector on the cycle after the strobe.
- R4: Save register 0 receives the next program counter for bits 0, 2, 7, 8 and 9. It receives the current program counter for bits 1, 3, 5 and 6.
- R5: Save register 1 receives the machine state ANDed with 0x87C0FFFF. For bit 0, bit 30 is also set. For bit 1, the masked value is ORed into the existing contents.
- R6: On every vectored exception, machine-state bit 0 takes the value of bit 16, and the result is then ANDed with the inverse of 0x0004EF36. This clears bit 15 among others.
- R7: When bit 4 is selected, bits 4 and 5 are cleared, taken_o stays low, and no counter, machine-state or save register changes.
- R8: Bits 7, 8 and 9 are eligible only when bits 0..6 are clear and machine-state bit 15 is 1. Their priority is 7, then 8, then 9.
- R9: The serviced flag is cleared and all other flags stay pending. A flag raised in the same cycle as its clear remains set.
- R10: taken_o and vector_o are valid combinationally in the strobe cycle. Without a strobe, or with no eligible exception, taken_o is low and nothing is written.
- R11: A vectored exception overrides a state load issued in the same cycle, and it is computed from the state held before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| take_i | input | 1 | Strobe: service one exception now |
| raise_i | input | 10 | Flags ORed into the pending register |
| state_ld_i | input | 1 | Load the counters, machine state and save register 1 |
| ld_pc_i | input | 32 | Current program counter to load |
| ld_npc_i | input | 32 | Next program counter to load |
| ld_msr_i | input | 32 | Machine state to load |
| ld_srr1_i | input | 32 | Save register 1 value to load |
| taken_o | output | 1 | A vectored exception is taken this cycle |
| vector_o | output | 32 | Handler address of the selected exception |
| pending_o | output | 10 | Pending flags |
| pc_o | output | 32 | Current program counter |
| npc_o | output | 32 | Next program counter |
| msr_o | output | 32 | Machine state |
| srr0_o | output | 32 | Save register 0 (return address) |
| srr1_o | output | 32 | Save register 1 (saved state) |

## Verification
A wrong priority decision or a stale pending bit shows combinationally on vector_o in the same strobe cycle, so it is caught before any state is written. A wrong save source, save mask or machine-state rewrite appears on the register outputs one cycle after the strobe. A clear that hits the wrong flag appears on pending_o at the same time. A leak of the memory-check cancel or of the enable gate into the register file shows up as a changed counter or save register on the next cycle, where it should have stayed steady.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned XW       = 32;
  localparam int unsigned NUM_EXC  = 10;
  localparam int unsigned NUM_SYNC = 7;

  localparam int unsigned E_ISI  = 0;
  localparam int unsigned E_PROG = 1;
  localparam int unsigned E_SC   = 2;
  localparam int unsigned E_FPU  = 3;
  localparam int unsigned E_MCHK = 4;
  localparam int unsigned E_DSI  = 5;
  localparam int unsigned E_ALGN = 6;
  localparam int unsigned E_EXT  = 7;
  localparam int unsigned E_PERF = 8;
  localparam int unsigned E_DEC  = 9;

  localparam int unsigned MSR_LE  = 0;
  localparam int unsigned MSR_EE  = 15;
  localparam int unsigned MSR_ILE = 16;

  localparam logic [XW-1:0] SAVE_KEEP = 32'h87C0_FFFF;
  localparam logic [XW-1:0] MSR_DROP  = 32'h0004_EF36;
  localparam logic [XW-1:0] ISI_MARK  = 32'h4000_0000;

  function automatic logic [XW-1:0] handler_addr(input int unsigned idx);
    case (idx)
      E_ISI:   return 32'h0000_0400;
      E_PROG:  return 32'h0000_0700;
      E_SC:    return 32'h0000_0C00;
      E_FPU:   return 32'h0000_0800;
      E_DSI:   return 32'h0000_0300;
      E_ALGN:  return 32'h0000_0600;
      E_EXT:   return 32'h0000_0500;
      E_PERF:  return 32'h0000_0F00;
      E_DEC:   return 32'h0000_0900;
      default: return '0;
    endcase
  endfunction

  function automatic logic resume_after(input int unsigned idx);
    return (idx == E_ISI) || (idx == E_SC) || (idx >= E_EXT);
  endfunction
endpackage

// File: rtl/exc_select.sv
module exc_select
  import exc_pkg::*;
(
  input  logic [NUM_EXC-1:0] pend,
  input  logic               ee,
  input  logic               take,
  output logic [NUM_EXC-1:0] grant,
  output logic               vec_take,
  output logic               cancel,
  output logic [XW-1:0]      vector,
  output logic               use_next
);
  logic found;

  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int unsigned i = 0; i < NUM_SYNC; i++) begin
      if (!found && pend[i]) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
    for (int unsigned i = NUM_SYNC; i < NUM_EXC; i++) begin
      if (!found && ee && pend[i]) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    vector   = '0;
    use_next = 1'b0;
    for (int unsigned i = 0; i < NUM_EXC; i++) begin
      if (grant[i]) begin
        vector   = vector | handler_addr(i);
        use_next = use_next | resume_after(i);
      end
    end
  end

  assign cancel   = take && grant[E_MCHK];
  assign vec_take = take && (|grant) && !grant[E_MCHK];
endmodule

// File: rtl/exc_ctx_calc.sv
module exc_ctx_calc
  import exc_pkg::*;
(
  input  logic [XW-1:0] msr,
  input  logic [XW-1:0] srr1_cur,
  input  logic [XW-1:0] pc,
  input  logic [XW-1:0] npc,
  input  logic          is_isi,
  input  logic          is_prog,
  input  logic          use_next,
  output logic [XW-1:0] msr_new,
  output logic [XW-1:0] srr0_new,
  output logic [XW-1:0] srr1_new
);
  logic [XW-1:0] kept;
  logic [XW-1:0] msr_le;

  always_comb begin
    kept = msr & SAVE_KEEP;
    if (is_isi)       srr1_new = kept | ISI_MARK;
    else if (is_prog) srr1_new = srr1_cur | kept;
    else              srr1_new = kept;

    srr0_new = use_next ? npc : pc;

    msr_le         = msr;
    msr_le[MSR_LE] = msr[MSR_ILE];
    msr_new        = msr_le & ~MSR_DROP;
  end
endmodule

// File: rtl/exc_vector_ctrl.sv
module exc_vector_ctrl
  import exc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take_i,
  input  logic [NUM_EXC-1:0]  raise_i,
  input  logic                state_ld_i,
  input  logic [XW-1:0]       ld_pc_i,
  input  logic [XW-1:0]       ld_npc_i,
  input  logic [XW-1:0]       ld_msr_i,
  input  logic [XW-1:0]       ld_srr1_i,
  output logic                taken_o,
  output logic [XW-1:0]       vector_o,
  output logic [NUM_EXC-1:0]  pending_o,
  output logic [XW-1:0]       pc_o,
  output logic [XW-1:0]       npc_o,
  output logic [XW-1:0]       msr_o,
  output logic [XW-1:0]       srr0_o,
  output logic [XW-1:0]       srr1_o
);
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [NUM_EXC-1:0] pend_q, pend_d, clr_mask;
  logic [XW-1:0] pc_q, pc_d, npc_q, npc_d, msr_q, msr_d;
  logic [XW-1:0] srr0_q, srr0_d, srr1_q, srr1_d;

  logic [NUM_EXC-1:0] grant_w;
  logic               vec_take, cancel, use_next;
  logic [XW-1:0]      vector;
  logic [XW-1:0]      msr_new, srr0_new, srr1_new;

  exc_select u_sel (
    .pend     (pend_q),
    .ee       (msr_q[MSR_EE]),
    .take     (take_i),
    .grant    (grant_w),
    .vec_take (vec_take),
    .cancel   (cancel),
    .vector   (vector),
    .use_next (use_next)
  );

  exc_ctx_calc u_ctx (
    .msr      (msr_q),
    .srr1_cur (srr1_q),
    .pc       (pc_q),
    .npc      (npc_q),
    .is_isi   (grant_w[E_ISI]),
    .is_prog  (grant_w[E_PROG]),
    .use_next (use_next),
    .msr_new  (msr_new),
    .srr0_new (srr0_new),
    .srr1_new (srr1_new)
  );

  always_comb begin
    clr_mask = '0;
    if (vec_take) clr_mask = grant_w;
    if (cancel) begin
      clr_mask[E_MCHK] = 1'b1;
      clr_mask[E_DSI]  = 1'b1;
    end
    pend_d = (pend_q & ~clr_mask) | raise_i;

    pc_d   = pc_q;
    npc_d  = npc_q;
    msr_d  = msr_q;
    srr0_d = srr0_q;
    srr1_d = srr1_q;
    if (vec_take) begin
      pc_d   = vector;
      npc_d  = vector;
      msr_d  = msr_new;
      srr0_d = srr0_new;
      srr1_d = srr1_new;
    end else if (state_ld_i) begin
      pc_d   = ld_pc_i;
      npc_d  = ld_npc_i;
      msr_d  = ld_msr_i;
      srr1_d = ld_srr1_i;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pend_q <= '0;
      pc_q   <= '0;
      npc_q  <= '0;
      msr_q  <= '0;
      srr0_q <= '0;
      srr1_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (vec_take || state_ld_i) begin
        pc_q  <= pc_d;
        npc_q <= npc_d;
        msr_q <= msr_d;
        srr1_q <= srr1_d;
      end
      if (vec_take) srr0_q <= srr0_d;
    end
  end

  assign taken_o   = vec_take;
  assign vector_o  = vector;
  assign pending_o = pend_q;
  assign pc_o      = pc_q;
  assign npc_o     = npc_q;
  assign msr_o     = msr_q;
  assign srr0_o    = srr0_q;
  assign srr1_o    = srr1_q;
endmodule

// File: rtl/exc_vector_ctrl_chk.sv
module exc_vector_ctrl_chk
  import exc_pkg::*;
(
  input logic               clk,
  input logic               rst_int_n,
  input logic               take_i,
  input logic               state_ld_i,
  input logic [NUM_EXC-1:0] raise_i,
  input logic [NUM_EXC-1:0] grant_w,
  input logic               taken_o,
  input logic [XW-1:0]      vector_o,
  input logic [NUM_EXC-1:0] pending_o,
  input logic [XW-1:0]      pc_o,
  input logic [XW-1:0]      npc_o,
  input logic [XW-1:0]      msr_o,
  input logic [XW-1:0]      srr0_o,
  input logic [XW-1:0]      srr1_o
);
  a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(grant_w));

  a_r3_redirect: assert property (@(posedge clk) disable iff (!rst_int_n)
    taken_o |=> (pc_o == $past(vector_o)) && (npc_o == $past(vector_o)));

  a_r6_ee_dropped: assert property (@(posedge clk) disable iff (!rst_int_n)
    taken_o |=> !msr_o[MSR_EE]);

  a_r7_cancel_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    (take_i && pending_o[E_MCHK] && pending_o[3:0] == 4'b0 && !state_ld_i && !raise_i[E_DSI])
    |=> $stable(pc_o) && $stable(msr_o) && $stable(srr0_o) && $stable(srr1_o) && !pending_o[E_DSI]);

  a_r8_gate: assert property (@(posedge clk) disable iff (!rst_int_n)
    (take_i && pending_o[NUM_SYNC-1:0] == '0 && !msr_o[MSR_EE]) |-> !taken_o);

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_int_n)
    (taken_o && (raise_i & grant_w) == '0) |=> (pending_o & $past(grant_w)) == '0);

  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    !take_i |-> !taken_o);
endmodule

bind exc_vector_ctrl exc_vector_ctrl_chk u_chk (
  .clk        (clk),
  .rst_int_n  (rst_int_n),
  .take_i     (take_i),
  .state_ld_i (state_ld_i),
  .raise_i    (raise_i),
  .grant_w    (grant_w),
  .taken_o    (taken_o),
  .vector_o   (vector_o),
  .pending_o  (pending_o),
  .pc_o       (pc_o),
  .npc_o      (npc_o),
  .msr_o      (msr_o),
  .srr0_o     (srr0_o),
  .srr1_o     (srr1_o)
);

// File: tb/tb_exc_vector_ctrl.sv
module tb_exc_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        take_i, state_ld_i;
  logic [9:0]  raise_i;
  logic [31:0] ld_pc_i, ld_npc_i, ld_msr_i, ld_srr1_i;
  logic        taken_o;
  logic [31:0] vector_o, pc_o, npc_o, msr_o, srr0_o, srr1_o;
  logic [9:0]  pending_o;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  exc_vector_ctrl dut (
    .clk(clk), .rst_n(rst_n), .take_i(take_i), .raise_i(raise_i),
    .state_ld_i(state_ld_i), .ld_pc_i(ld_pc_i), .ld_npc_i(ld_npc_i),
    .ld_msr_i(ld_msr_i), .ld_srr1_i(ld_srr1_i), .taken_o(taken_o),
    .vector_o(vector_o), .pending_o(pending_o), .pc_o(pc_o), .npc_o(npc_o),
    .msr_o(msr_o), .srr0_o(srr0_o), .srr1_o(srr1_o)
  );

  localparam logic [31:0] PC0  = 32'h0000_2000;
  localparam logic [31:0] NPC0 = 32'h0000_2004;

  typedef struct packed {
    logic [9:0]  raise;
    logic [31:0] msr;
    logic [31:0] srr1;
    logic        tk;
    logic [31:0] vec;
    logic        nxt;
    logic [9:0]  pend;
  } row_t;

  localparam row_t TBL [12] = '{
    '{10'h001, 32'h0001_A032, 32'h0000_0000, 1'b1, 32'h400, 1'b1, 10'h000},
    '{10'h203, 32'h0001_A032, 32'h0000_0000, 1'b1, 32'h400, 1'b1, 10'h202},
    '{10'h002, 32'h0000_A003, 32'h0002_0000, 1'b1, 32'h700, 1'b0, 10'h000},
    '{10'h00C, 32'h0001_A032, 32'h0000_0000, 1'b1, 32'hC00, 1'b1, 10'h008},
    '{10'h008, 32'h0001_A032, 32'h0000_0000, 1'b1, 32'h800, 1'b0, 10'h000},
    '{10'h060, 32'h0001_A032, 32'h0000_0000, 1'b1, 32'h300, 1'b0, 10'h040},
    '{10'h040, 32'h0001_A032, 32'h0000_0000, 1'b1, 32'h600, 1'b0, 10'h000},
    '{10'h380, 32'h0001_8000, 32'h0000_0000, 1'b1, 32'h500, 1'b1, 10'h300},
    '{10'h300, 32'h0001_8000, 32'h0000_0000, 1'b1, 32'hF00, 1'b1, 10'h200},
    '{10'h200, 32'h0001_8000, 32'h0000_0000, 1'b1, 32'h900, 1'b1, 10'h000},
    '{10'h200, 32'h0001_0000, 32'h0000_0005, 1'b0, 32'h000, 1'b0, 10'h200},
    '{10'h070, 32'h0001_A032, 32'h0000_0005, 1'b0, 32'h000, 1'b0, 10'h040}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_msr(input logic [31:0] m);
    logic [31:0] t;
    t = m;
    t[0] = m[16];
    return t & ~32'h0004_EF36;
  endfunction

  function automatic logic [31:0] exp_srr1(input logic [31:0] m, input logic [31:0] pre,
                                           input logic [31:0] vec);
    logic [31:0] k;
    k = m & 32'h87C0_FFFF;
    if (vec == 32'h400) return k | 32'h4000_0000;
    if (vec == 32'h700) return pre | k;
    return k;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    take_i = 0; state_ld_i = 0; raise_i = '0;
    ld_pc_i = '0; ld_npc_i = '0; ld_msr_i = '0; ld_srr1_i = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic prep(input logic [9:0] r, input logic [31:0] m, input logic [31:0] s1);
    raise_i = r;
    @(negedge clk);
    raise_i = '0;
    state_ld_i = 1; ld_pc_i = PC0; ld_npc_i = NPC0; ld_msr_i = m; ld_srr1_i = s1;
    @(negedge clk);
    state_ld_i = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    check("R1 pending", {22'b0, pending_o}, 32'h0);
    check("R1 pc", pc_o, 32'h0);
    check("R1 npc", npc_o, 32'h0);
    check("R1 msr", msr_o, 32'h0);
    check("R1 srr0", srr0_o, 32'h0);
    check("R1 srr1", srr1_o, 32'h0);

    for (int i = 0; i < 12; i++) begin
      do_reset();
      prep(TBL[i].raise, TBL[i].msr, TBL[i].srr1);
      take_i = 1;
      #1;
      // R2 R3 R8 R10: selection visible in the strobe cycle
      check("R10 R8 taken", {31'b0, taken_o}, {31'b0, TBL[i].tk});
      if (TBL[i].tk) check("R2 R3 vector", vector_o, TBL[i].vec);
      @(negedge clk);
      take_i = 0;
      if (TBL[i].tk) begin
        check("R3 pc", pc_o, TBL[i].vec);
        check("R3 npc", npc_o, TBL[i].vec);
        check("R4 srr0", srr0_o, TBL[i].nxt ? NPC0 : PC0);
        check("R5 srr1", srr1_o, exp_srr1(TBL[i].msr, TBL[i].srr1, TBL[i].vec));
        check("R6 msr", msr_o, exp_msr(TBL[i].msr));
      end else begin
        // R7 R10: no write when nothing is vectored
        check("R7 R10 pc", pc_o, PC0);
        check("R7 R10 npc", npc_o, NPC0);
        check("R7 R10 msr", msr_o, TBL[i].msr);
        check("R7 R10 srr0", srr0_o, 32'h0);
        check("R7 R10 srr1", srr1_o, TBL[i].srr1);
      end
      check("R9 R7 pending", {22'b0, pending_o}, {22'b0, TBL[i].pend});
    end

    // R10: pending but no strobe
    do_reset();
    prep(10'h004, 32'h0001_A032, 32'h0);
    #1;
    check("R10 no strobe", {31'b0, taken_o}, 32'h0);
    @(negedge clk);
    check("R10 no strobe pc", pc_o, PC0);

    // R9 and R11: re-raise of the serviced flag and a load in the strobe cycle
    take_i = 1; raise_i = 10'h004;
    state_ld_i = 1; ld_pc_i = 32'h5555_0000; ld_npc_i = 32'h5555_0004;
    ld_msr_i = 32'h0000_8000; ld_srr1_i = 32'h1;
    @(negedge clk);
    take_i = 0; raise_i = '0; state_ld_i = 0;
    check("R11 pc", pc_o, 32'hC00);
    check("R11 srr0", srr0_o, NPC0);
    check("R11 msr", msr_o, exp_msr(32'h0001_A032));
    check("R9 reraise", {22'b0, pending_o}, 32'h004);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule